// File: doc/BRIEF.md
# SDRAM burst column sequencer

This block is the burst engine on the device side of a synchronous DRAM model. Each clock it takes one registered command (NOP, READ or WRITE) together with a bank and a starting column. For the rest of the burst it works out the column addresses itself. Read words leave through a latency pipeline of the programmed depth. Write words are stored into a small register-based array, and a per-beat mask can block any single word.

A clock-enable input stalls the internal clock one edge late. When the enable is sampled low on a rising edge, the next internal edge does not happen. On that suspended edge, commands and write data are ignored, the burst counter stays where it is, and the read outputs keep their value. A mode word, loaded through a dedicated strobe, sets the following:
- the burst length;
- the wrap order, sequential or interleaved;
- the read latency;
- a flag that cuts every write down to a single column while reads keep the full burst.

Top module: `sdram_burst_seq`

## Requirements
- R1: After reset `rvalid` is low and the mode is burst length 1, sequential order, read latency 2, single-column writes off.
- R2: With `mode_ld` high on an active internal edge, `mode_word` is taken as follows. Bits [2:0] are the burst length code (0→1, 1→2, 2→4, any other→8). Bit 3 picks interleaved order (1) or sequential order (0). Bits [6:4] give the read latency (1..MAX_CL; other values act as MAX_CL). Bit 7 makes writes single-column. Commands use the new mode from the following edge.
- R3: For a READ registered on internal edge E, the word of the first column is on `rdata` with `rvalid` high after internal edge E+CL-1. Each following column comes one internal edge later.
- R4: In sequential order, burst beat i addresses column (start+i) mod BL inside the BL-aligned block that holds the start column. The upper column bits never change.
- R5: In interleaved order, burst beat i addresses the low column bits start XOR i inside the same aligned block.
- R6: A WRITE stores `wdata` on its own edge and on each of the next BL-1 internal edges, at the burst columns, with command encoding NOP=0, READ=1, WRITE=2.
- R7: A write beat with `dm` high leaves that column unchanged.
- R8: With the single-write bit set, a WRITE stores one column only, and READs still return BL words in the programmed order.
- R9: A READ or WRITE arriving while a burst is running ends that burst at once. Its remaining columns are never accessed, and the new burst starts on that edge.
- R10: When `cke` is sampled low on a rising edge, the following edge is suspended. The command and write data present at that edge are ignored and the burst column does not advance.
- R11: Across a suspended edge, `rdata` and `rvalid` keep the values they had before it.
- R12: When `cke` is sampled high, the next rising edge is active again and the burst resumes from the column where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable; low suspends the next internal edge |
| mode_ld | input | 1 | Load strobe for the mode word |
| mode_word | input | 8 | Burst length, order, read latency, single-write flag |
| cmd | input | 2 | Command: 0 NOP, 1 READ, 2 WRITE |
| bank | input | BANK_W | Bank of the command |
| col | input | COL_W | Starting column of the command |
| wdata | input | DATA_W | Write word for the current beat |
| dm | input | 1 | Blocks storing the current write beat |
| rdata | output | DATA_W | Read word |
| rvalid | output | 1 | `rdata` carries a burst word |

## Verification
Bursts are read back with every length, from starting columns in the middle and at the end of the aligned block. They are read in both orders, so that an error in the wrap or XOR step shows up as a misplaced word. Reads run under two latencies, which separates pipeline depth from column order. One read is cut short by a new read, to show that truncation drops only the tail of the old burst. Writes are checked with a mixed mask and with the single-column flag, and reading the neighbouring columns shows that nothing beyond the intended beats was stored. Separate tests suspend a read burst and a write burst, each for one edge, with a conflicting command or junk data on the suspended edge. These tell apart a correct one-edge-late stall from an immediate stall, from a counter that keeps running, and from inputs that are taken while suspended.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

   typedef enum logic [1:0] {
      SBS_NOP   = 2'd0,
      SBS_READ  = 2'd1,
      SBS_WRITE = 2'd2
   } sbs_cmd_e;

   // mode word layout, MSB first
   typedef struct packed {
      logic       wr_single;
      logic [2:0] lat;
      logic       ilv;
      logic [2:0] blen;
   } sbs_mode_t;

   localparam int unsigned SBS_MODE_W = $bits(sbs_mode_t);

   localparam sbs_mode_t SBS_MODE_RST = '{wr_single: 1'b0, lat: 3'd2, ilv: 1'b0, blen: 3'd0};

   // mask of the low column bits that wrap inside a burst
   function automatic logic [2:0] sbs_wrap_mask(input logic [2:0] code);
      case (code)
         3'd0:    return 3'd0;
         3'd1:    return 3'd1;
         3'd2:    return 3'd3;
         default: return 3'd7;
      endcase
   endfunction

endpackage

// File: rtl/sbs_store.sv
module sbs_store #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem_q[addr] <= wdata;
   end

   assign rdata = mem_q[addr];

endmodule

// File: rtl/sbs_col_gen.sv
module sbs_col_gen
   import sbs_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int COL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ien,
   input  sbs_cmd_e          cmd,
   input  logic [BANK_W-1:0] bank_in,
   input  logic [COL_W-1:0]  col_in,
   input  sbs_mode_t         mode,
   output logic              acc_vld,
   output logic              acc_rd,
   output logic [BANK_W-1:0] acc_bank,
   output logic [COL_W-1:0]  acc_col
);
   logic [COL_W-1:0]  start_q;
   logic [BANK_W-1:0] bank_q;
   logic              rd_q;
   logic [2:0]        idx_q;
   logic [2:0]        left_q;
   logic [2:0]        mask;
   logic [2:0]        low_raw;
   logic [2:0]        low_new;
   logic [COL_W-1:0]  next_col;
   logic              new_cmd;
   logic              cont;

   assign mask    = sbs_wrap_mask(mode.blen);
   assign low_raw = mode.ilv ? (start_q[2:0] ^ idx_q) : (start_q[2:0] + idx_q);
   assign low_new = (low_raw & mask) | (start_q[2:0] & ~mask);

   generate
      if (COL_W == 3) begin : g_narrow
         assign next_col = low_new;
      end else begin : g_wide
         assign next_col = {start_q[COL_W-1:3], low_new};
      end
   endgenerate

   always_comb begin
      new_cmd  = ien && (cmd == SBS_READ || cmd == SBS_WRITE);
      cont     = ien && !new_cmd && (left_q != 3'd0);
      acc_vld  = new_cmd || cont;
      acc_rd   = new_cmd ? (cmd == SBS_READ) : rd_q;
      acc_bank = new_cmd ? bank_in : bank_q;
      acc_col  = new_cmd ? col_in : next_col;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         bank_q  <= '0;
         rd_q    <= 1'b0;
         idx_q   <= '0;
         left_q  <= '0;
      end else if (new_cmd) begin
         start_q <= col_in;
         bank_q  <= bank_in;
         rd_q    <= (cmd == SBS_READ);
         idx_q   <= 3'd1;
         left_q  <= (cmd == SBS_WRITE && mode.wr_single) ? 3'd0 : mask;
      end else if (cont) begin
         idx_q  <= idx_q + 3'd1;
         left_q <= left_q - 3'd1;
      end
   end

endmodule

// File: rtl/sbs_rd_pipe.sv
module sbs_rd_pipe #(
   parameter int DATA_W = 16,
   parameter int MAX_CL = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ien,
   input  logic              in_vld,
   input  logic [DATA_W-1:0] in_data,
   input  logic [2:0]        lat,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_data
);
   localparam int SEL_W = $clog2(MAX_CL);

   logic              vld_q [MAX_CL];
   logic [DATA_W-1:0] dat_q [MAX_CL];
   logic [SEL_W-1:0]  sel;

   generate
      for (genvar g = 0; g < MAX_CL; g++) begin : g_stage
         if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  vld_q[0] <= 1'b0;
                  dat_q[0] <= '0;
               end else if (ien) begin
                  vld_q[0] <= in_vld;
                  dat_q[0] <= in_data;
               end
            end
         end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  vld_q[g] <= 1'b0;
                  dat_q[g] <= '0;
               end else if (ien) begin
                  vld_q[g] <= vld_q[g-1];
                  dat_q[g] <= dat_q[g-1];
               end
            end
         end
      end
   endgenerate

   always_comb begin
      sel = SEL_W'(MAX_CL - 1);
      for (int i = 0; i < MAX_CL; i++) begin
         if (lat == 3'(i + 1)) sel = SEL_W'(i);
      end
   end

   assign out_vld  = vld_q[sel];
   assign out_data = dat_q[sel];

endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
   import sbs_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BANK_W = 2,
   parameter int COL_W  = 4,
   parameter int MAX_CL = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cke,
   input  logic              mode_ld,
   input  logic [7:0]        mode_word,
   input  logic [1:0]        cmd,
   input  logic [BANK_W-1:0] bank,
   input  logic [COL_W-1:0]  col,
   input  logic [DATA_W-1:0] wdata,
   input  logic              dm,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);
   localparam int ADDR_W = BANK_W + COL_W;

   generate
      if (COL_W < 3)                   begin : g_bad_col  $error("COL_W must be at least 3"); end
      if (BANK_W < 1)                  begin : g_bad_bank $error("BANK_W must be at least 1"); end
      if (DATA_W < 1)                  begin : g_bad_data $error("DATA_W must be at least 1"); end
      if (MAX_CL < 2 || MAX_CL > 7)    begin : g_bad_cl   $error("MAX_CL must lie in 2..7"); end
      if (SBS_MODE_W != 8)             begin : g_bad_mode $error("mode word must be 8 bits"); end
   endgenerate

   logic              cke_q;
   sbs_mode_t         mode_q;
   logic              acc_vld;
   logic              acc_rd;
   logic [BANK_W-1:0] acc_bank;
   logic [COL_W-1:0]  acc_col;
   logic [DATA_W-1:0] rd_word;

   // internal edge happens only if the enable was high one edge earlier
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cke_q <= 1'b1;
      else        cke_q <= cke;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                mode_q <= SBS_MODE_RST;
      else if (cke_q && mode_ld) mode_q <= sbs_mode_t'(mode_word);
   end

   sbs_col_gen #(
      .BANK_W (BANK_W),
      .COL_W  (COL_W)
   ) u_col_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .ien      (cke_q),
      .cmd      (sbs_cmd_e'(cmd)),
      .bank_in  (bank),
      .col_in   (col),
      .mode     (mode_q),
      .acc_vld  (acc_vld),
      .acc_rd   (acc_rd),
      .acc_bank (acc_bank),
      .acc_col  (acc_col)
   );

   sbs_store #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_store (
      .clk   (clk),
      .we    (acc_vld && !acc_rd && !dm),
      .addr  ({acc_bank, acc_col}),
      .wdata (wdata),
      .rdata (rd_word)
   );

   sbs_rd_pipe #(
      .DATA_W (DATA_W),
      .MAX_CL (MAX_CL)
   ) u_rd_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .ien      (cke_q),
      .in_vld   (acc_vld && acc_rd),
      .in_data  (rd_word),
      .lat      (mode_q.lat),
      .out_vld  (rvalid),
      .out_data (rdata)
   );

endmodule

// File: rtl/sbs_chk.sv
module sbs_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic              ien,
   input logic [1:0]        cmd,
   input logic              acc_vld,
   input logic              acc_rd,
   input logic              wr_single,
   input logic [2:0]        blen,
   input logic [DATA_W-1:0] rdata,
   input logic              rvalid
);
   logic       new_c;
   logic [3:0] run_q;
   logic [3:0] beats;

   assign new_c = ien && (cmd == 2'd1 || cmd == 2'd2);
   assign beats = (blen == 3'd0) ? 4'd1 : (blen == 3'd1) ? 4'd2 : (blen == 3'd2) ? 4'd4 : 4'd8;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= '0;
      else if (acc_vld) run_q <= new_c ? 4'd1 : run_q + 4'd1;
   end

   // R10
   susp_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ien |-> !acc_vld);

   // R11
   susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |=> ##1 ($stable(rdata) && $stable(rvalid)));

   // R8
   single_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && !acc_rd && wr_single) |-> new_c);

   // R6
   burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld && !new_c) |-> (run_q < beats));

endmodule

bind sdram_burst_seq sbs_chk #(.DATA_W(DATA_W)) u_sbs_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke       (cke),
   .ien       (cke_q),
   .cmd       (cmd),
   .acc_vld   (acc_vld),
   .acc_rd    (acc_rd),
   .wr_single (mode_q.wr_single),
   .blen      (mode_q.blen),
   .rdata     (rdata),
   .rvalid    (rvalid)
);

// File: tb/test_sdram_burst_seq.sv
module test_sdram_burst_seq;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int BW = 2;
   localparam int CW = 4;
   localparam int NCOL = 1 << CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cke = 1'b1;
   logic          mode_ld = 1'b0;
   logic [7:0]    mode_word = '0;
   logic [1:0]    cmd = 2'd0;
   logic [BW-1:0] bank = '0;
   logic [CW-1:0] col = '0;
   logic [DW-1:0] wdata = '0;
   logic          dm = 1'b0;
   logic [DW-1:0] rdata;
   logic          rvalid;

   sdram_burst_seq #(.DATA_W(DW), .BANK_W(BW), .COL_W(CW), .MAX_CL(3)) i_sdram_burst_seq (
      .clk(clk), .rst_n(rst_n), .cke(cke), .mode_ld(mode_ld), .mode_word(mode_word),
      .cmd(cmd), .bank(bank), .col(col), .wdata(wdata), .dm(dm),
      .rdata(rdata), .rvalid(rvalid)
   );

   typedef struct {
      int          cyc;
      logic [15:0] data;
      string       req;
   } exp_t;

   exp_t        sb[$];
   int          cyc = 0;
   int          n_chk = 0;
   int          n_fail = 0;
   logic [15:0] shadow [NCOL * 4];
   int          bl = 1;
   bit          ilv = 1'b0;
   int          cl = 2;
   bit          m9 = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int col_at(int start, int i);
      int m  = bl - 1;
      int lo = ilv ? ((start & 7) ^ i) : ((start & 7) + i);
      return (start & ~m) | (lo & m);
   endfunction

   task automatic push_exp(int at, int b, int c, string req);
      exp_t e;
      e.cyc  = at;
      e.data = shadow[b * NCOL + c];
      e.req  = req;
      sb.push_back(e);
   endtask

   task automatic set_mode(int code, bit il, int lat, bit single);
      repeat (6) @(negedge clk);
      mode_ld   = 1'b1;
      mode_word = {single, 3'(lat), il, 3'(code)};
      @(negedge clk);
      mode_ld = 1'b0;
      bl  = (code == 0) ? 1 : (code == 1) ? 2 : (code == 2) ? 4 : 8;
      ilv = il;
      cl  = lat;
      m9  = single;
   endtask

   task automatic do_read(int b, int c, int n, string req);
      for (int i = 0; i < n; i++) push_exp(cyc + cl + i, b, col_at(c, i), req);
      cmd  = 2'd1;
      bank = BW'(b);
      col  = CW'(c);
      @(negedge clk);
      cmd = 2'd0;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic do_write(int b, int c, int seed, int mask);
      int eff = m9 ? 1 : bl;
      cmd  = 2'd2;
      bank = BW'(b);
      col  = CW'(c);
      for (int i = 0; i < bl; i++) begin
         wdata = DW'(seed + i);
         dm    = mask[i];
         if (i < eff && !mask[i]) shadow[b * NCOL + col_at(c, i)] = DW'(seed + i);
         @(negedge clk);
         cmd = 2'd0;
      end
      dm = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      exp_t e;
      if (rst_n) begin
         if (rvalid) begin
            n_chk++;
            if (sb.size() == 0) begin
               n_fail++;
               $display("FAIL unexpected read word at cycle %0d: actual %h expected none", cyc, rdata);
            end else begin
               e = sb.pop_front();
               if (e.cyc != cyc || e.data != rdata) begin
                  n_fail++;
                  $display("FAIL %s: actual %h at cycle %0d, expected %h at cycle %0d",
                           e.req, rdata, cyc, e.data, e.cyc);
               end
            end
         end else if (sb.size() > 0 && sb[0].cyc <= cyc) begin
            e = sb.pop_front();
            n_chk++;
            n_fail++;
            $display("FAIL %s: actual no word at cycle %0d, expected %h", e.req, cyc, e.data);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      int base;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: quiet after reset
      n_chk++;
      if (rvalid !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: actual rvalid %b expected 0", rvalid);
      end
      // R1: default mode is BL1, latency 2
      do_write(0, 3, 16'h1234, 0);
      do_read(0, 3, 1, "R1");

      // R2 R6: BL8 fill of every bank
      set_mode(3, 1'b0, 2, 1'b0);
      for (int b = 0; b < 4; b++) begin
         for (int h = 0; h < 2; h++) begin
            base = 16'h0100 + b * 16'h1000 + h * 16'h0080;
            do_write(b, h * 8, base, 0);
         end
      end
      do_read(0, 0, 8, "R6");
      do_read(2, 8, 8, "R6");
      // R4: sequential wrap from the end of the block
      do_read(1, 13, 8, "R4");

      // R2 R3: BL4 with latency 3
      set_mode(2, 1'b0, 3, 1'b0);
      do_read(3, 6, 4, "R3");

      // R5: interleaved orders
      set_mode(3, 1'b1, 2, 1'b0);
      do_read(1, 5, 8, "R5");
      set_mode(1, 1'b1, 3, 1'b0);
      do_read(2, 7, 2, "R5");

      // R7: masked beats
      set_mode(2, 1'b0, 2, 1'b0);
      do_write(2, 4, 16'h7000, 4'b0101);
      do_read(2, 4, 4, "R7");

      // R8: single-column writes, full-length reads
      set_mode(2, 1'b0, 2, 1'b1);
      do_write(3, 2, 16'h8000, 0);
      do_read(3, 0, 4, "R8");

      // R9: truncation of a read by a new read
      set_mode(2, 1'b0, 2, 1'b0);
      do_read(0, 0, 1, "R9");
      do_read(0, 8, 4, "R9");

      // R10 R11 R12: suspend during a read burst
      repeat (6) @(negedge clk);
      push_exp(cyc + 2, 0, 4, "R12");
      push_exp(cyc + 3, 0, 4, "R11");
      push_exp(cyc + 4, 0, 5, "R12");
      push_exp(cyc + 5, 0, 6, "R12");
      push_exp(cyc + 6, 0, 7, "R12");
      cmd = 2'd1; bank = 2'd0; col = 4'd4;
      @(negedge clk);
      cmd = 2'd0; cke = 1'b0;
      @(negedge clk);
      cke = 1'b1; cmd = 2'd2; bank = 2'd0; col = 4'd0; wdata = 16'hDEAD;
      @(negedge clk);
      cmd = 2'd0;
      repeat (8) @(negedge clk);

      // R10 R12: suspend during a write burst
      cmd = 2'd2; bank = 2'd1; col = 4'd8; wdata = 16'hA000;
      shadow[1 * NCOL + 8] = 16'hA000;
      @(negedge clk);
      cmd = 2'd0; cke = 1'b0; wdata = 16'hA001;
      shadow[1 * NCOL + 9] = 16'hA001;
      @(negedge clk);
      cke = 1'b1; wdata = 16'hBAD1;
      @(negedge clk);
      wdata = 16'hA002;
      shadow[1 * NCOL + 10] = 16'hA002;
      @(negedge clk);
      wdata = 16'hA003;
      shadow[1 * NCOL + 11] = 16'hA003;
      @(negedge clk);
      repeat (2) @(negedge clk);
      do_read(0, 0, 4, "R10");
      do_read(1, 8, 4, "R10");
      repeat (10) @(negedge clk);

      n_chk++;
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL R3: actual %0d words outstanding expected 0", sb.size());
      end
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule